// File: doc/BRIEF.md
# Trigger-Free Strip Hit Collector with Crossing Stamp

This block gathers discriminator hits from 128 strip channels arranged as 16 groups of 8 and reports every hit without waiting for a trigger. Each reported hit is a record with three fields: a 5-bit group number, a 4-bit strip number that selects one of the group's 8 strips, and the 8-bit beam-crossing count of the crossing in which the hit was seen. The collector runs on the beam-crossing clock, and one clock cycle is one crossing. The crossing period may be 132, 264 or 396 ns. A per-channel kill mask silences noisy channels. A global reject control drops new hits. A send enable gates the flow of records toward the output. An acquire command copies the running crossing count into a holding register.

Each group takes a snapshot of all its live hits in one crossing and stamps them. It then gives up one strip per grant, lowest strip first. A group does not take a new crossing until the snapshot is empty. Hits that reach a busy group are added to a saturating loss counter. A round-robin arbiter picks one group per cycle and writes its record into a small dual-clock FIFO. The FIFO hands records to a formatter clocked by an unrelated readout clock over a valid/ready handshake. Groups are served by rotation, not by age, so records can leave out of time order.

Top module: `hitcore_top`

## Requirements
- R1: A group that holds no pending hits and sees at least one live hit (discriminator high, kill bit clear) while reject is low captures all its live hits in that cycle. The captured hits carry as stamp the value `crossingNow` shows during that cycle.
- R2: Every captured live hit produces exactly one record. The record's `outGroup` is the group index 0..15, where channel c belongs to group c/8. Its `outStrip` is c%8, and its `outStamp` is the capture stamp. The records of one group leave in ascending strip order.
- R3: A channel whose `killMask` bit is set never produces a record and never adds to `lostCount`.
- R4: `crossingNow` is 0 in reset, rises by one on every `bcoClk` edge, and wraps from 255 to 0.
- R5: While `sendData` is low, no record is written toward the output, and `outValid` stays low once earlier records have drained. Pending hits are kept and leave after `sendData` rises.
- R6: While `rejectHits` is high, hits are neither captured, reported nor counted as lost.
- R7: When several groups have pending hits, at most one record is taken per cycle. The next group served is the first group with pending hits after the one last served, counting upward with wrap-around. Group 0 is first after reset.
- R8: On a `bcoClk` edge where `acqCrossing` is high, `crossingHeld` takes the value of `crossingNow`. Otherwise `crossingHeld` keeps its value. It is 0 in reset.
- R9: Each live hit that arrives while reject is low and its group still holds pending hits adds one to `lostCount`. `lostCount` saturates at 65535.
- R10: In the `roClk` domain, a record shown with `outValid` high stays valid and unchanged until it is taken with `outReady`. Under any pattern of backpressure, no record is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcoClk | input | 1 | Beam-crossing clock, one cycle per crossing |
| roClk | input | 1 | Readout clock, unrelated to bcoClk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| discIn | input | 128 | Synchronous discriminator outputs, channel c on bit c |
| killMask | input | 128 | Per-channel kill bits, 1 silences the channel |
| rejectHits | input | 1 | Drop new hits while high |
| sendData | input | 1 | Allow records to move toward the output while high |
| acqCrossing | input | 1 | Copy the crossing count into crossingHeld |
| crossingNow | output | 8 | Running crossing count |
| crossingHeld | output | 8 | Crossing count captured by the last acquire |
| lostCount | output | 16 | Saturating count of hits lost at busy groups |
| outValid | output | 1 | A record is available (roClk domain) |
| outReady | input | 1 | Formatter takes the record (roClk domain) |
| outGroup | output | 5 | Group number of the record |
| outStrip | output | 4 | Strip number within the group |
| outStamp | output | 8 | Crossing stamp of the record |

## Verification
The bench sweeps 256 single-group crossings that rotate through all 16 groups, each with its own hit and kill pattern. A mask polarity error or a priority encoder that skips or repeats a strip shows up as a missing, extra or misordered record. Stamps are checked against the count shown in the capture cycle. An off-by-one there would shift every stamp. Multi-group snapshots, with one group captured a crossing later, check the rotation order against an arithmetic model. A fixed-priority arbiter or a pointer that does not advance would reorder those records. Hits at a busy group, hits under reject and a flood that drives the loss counter past its limit check the loss rules. A counter that wraps, that counts rejected or killed hits, or a busy group that takes new hits would show a wrong count or stray records. All of this runs under a readout backpressure pattern that would expose a FIFO that drops, repeats or changes a stalled record.

// File: rtl/hitcore_pkg.sv
package hitcore_pkg;
  localparam int NGROUPS  = 16;
  localparam int NSTRIPS  = 8;
  localparam int CHANNELS = NGROUPS * NSTRIPS;
  localparam int STRIPW   = 4;
  localparam int GROUPW   = 5;
  localparam int STAMPW   = 8;
  localparam int GSELW    = $clog2(NGROUPS);
  localparam int CNTW     = $clog2(NSTRIPS + 1);
  localparam int SUMW     = $clog2(CHANNELS + 1);

  typedef struct packed {
    logic [GROUPW-1:0] grp;
    logic [STRIPW-1:0] strip;
    logic [STAMPW-1:0] stamp;
  } hitRec_t;

  typedef struct packed {
    logic               push;
    logic [NGROUPS-1:0] grant;
  } ctrlStb_t;
endpackage

// File: rtl/hitcore_group.sv
module hitcore_group
  import hitcore_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSTRIPS-1:0] liveHits,
  input  logic              reject,
  input  logic [STAMPW-1:0] stampNow,
  input  logic              pop,
  output logic              hasWork,
  output logic [STRIPW-1:0] headStrip,
  output logic [STAMPW-1:0] heldStamp,
  output logic [CNTW-1:0]   lostInc
);
  logic [NSTRIPS-1:0] pend;
  logic [NSTRIPS-1:0] lowBit;
  logic               capture;

  assign hasWork = |pend;
  assign lowBit  = pend & (~pend + 1'b1);
  assign capture = !hasWork && !reject && (|liveHits);

  always_comb begin
    headStrip = '0;
    for (int i = 0; i < NSTRIPS; i++) begin
      if (lowBit[i]) headStrip = STRIPW'(i);
    end
  end

  always_comb begin
    lostInc = '0;
    if (hasWork && !reject) begin
      for (int i = 0; i < NSTRIPS; i++) lostInc = lostInc + CNTW'(liveHits[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend      <= '0;
      heldStamp <= '0;
    end else if (capture) begin
      pend      <= liveHits;
      heldStamp <= stampNow;
    end else if (pop) begin
      pend      <= pend & ~lowBit;
    end
  end

  AST_POP_HAS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> hasWork); // R2
  AST_REJECT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (reject && !hasWork) |=> !hasWork); // R6
  AST_BUSY_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    hasWork |=> ((pend & ~$past(pend)) == '0)); // R9
endmodule

// File: rtl/hitcore_ctrl.sv
module hitcore_ctrl
  import hitcore_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sendData,
  input  logic               acqCrossing,
  input  logic [NGROUPS-1:0] req,
  input  logic               fifoFull,
  output ctrlStb_t           stb,
  output logic [STAMPW-1:0]  crossNow,
  output logic [STAMPW-1:0]  crossHeld
);
  logic [GSELW-1:0] lastPtr;
  logic [GSELW-1:0] selIdx;
  logic             found;
  logic             allow;

  always_comb begin
    logic [GSELW-1:0] idx;
    found  = 1'b0;
    selIdx = lastPtr;
    for (int i = 1; i <= NGROUPS; i++) begin
      idx = GSELW'((int'(lastPtr) + i) % NGROUPS);
      if (!found && req[idx]) begin
        found  = 1'b1;
        selIdx = idx;
      end
    end
  end

  assign allow = sendData && !fifoFull;

  always_comb begin
    stb.push  = allow && found;
    stb.grant = '0;
    if (stb.push) stb.grant[selIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPtr   <= GSELW'(NGROUPS - 1);
      crossNow  <= '0;
      crossHeld <= '0;
    end else begin
      crossNow <= crossNow + 1'b1;
      if (acqCrossing) crossHeld <= crossNow;
      if (stb.push) lastPtr <= selIdx;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.grant)); // R7
  AST_CROSS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (crossNow == STAMPW'($past(crossNow) + 1'b1))); // R4
  AST_ACQ_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    acqCrossing |=> (crossHeld == $past(crossNow))); // R8
  AST_ACQ_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !acqCrossing |=> $stable(crossHeld)); // R8
  AST_SEND_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !sendData |-> !stb.push); // R5
endmodule

// File: rtl/hitcore_datapath.sv
module hitcore_datapath
  import hitcore_pkg::*;
#(
  parameter int LOSTW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHANNELS-1:0] discIn,
  input  logic [CHANNELS-1:0] killMask,
  input  logic                rejectHits,
  input  logic [STAMPW-1:0]   crossNow,
  input  ctrlStb_t            stb,
  output logic [NGROUPS-1:0]  req,
  output hitRec_t             wrRec,
  output logic [LOSTW-1:0]    lostCount
);
  logic [STRIPW-1:0] gStrip [NGROUPS];
  logic [STAMPW-1:0] gStamp [NGROUPS];
  logic [CNTW-1:0]   gLost  [NGROUPS];
  logic [SUMW-1:0]   lostSum;
  logic [LOSTW:0]    lostWide;

  for (genvar g = 0; g < NGROUPS; g++) begin : gGroup
    hitcore_group u_grp (
      .clk       (clk),
      .rstN      (rstN),
      .liveHits  (discIn[g*NSTRIPS +: NSTRIPS] & ~killMask[g*NSTRIPS +: NSTRIPS]),
      .reject    (rejectHits),
      .stampNow  (crossNow),
      .pop       (stb.grant[g]),
      .hasWork   (req[g]),
      .headStrip (gStrip[g]),
      .heldStamp (gStamp[g]),
      .lostInc   (gLost[g])
    );
  end

  always_comb begin
    wrRec = '0;
    for (int g = 0; g < NGROUPS; g++) begin
      if (stb.grant[g]) begin
        wrRec.grp   = GROUPW'(g);
        wrRec.strip = gStrip[g];
        wrRec.stamp = gStamp[g];
      end
    end
  end

  always_comb begin
    lostSum = '0;
    for (int g = 0; g < NGROUPS; g++) lostSum = lostSum + SUMW'(gLost[g]);
  end

  assign lostWide = {1'b0, lostCount} + (LOSTW+1)'(lostSum);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lostCount <= '0;
    else if (lostWide[LOSTW]) lostCount <= '1;
    else lostCount <= lostWide[LOSTW-1:0];
  end

  AST_LOST_MONO: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (lostCount >= $past(lostCount))); // R9
  AST_PUSH_FROM_WORK: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> ((stb.grant & req) != '0)); // R7
endmodule

// File: rtl/hitcore_afifo.sv
module hitcore_afifo #(
  parameter int W  = 17,
  parameter int AW = 3
) (
  input  logic         wClk,
  input  logic         rClk,
  input  logic         rstN,
  input  logic         wEn,
  input  logic [W-1:0] wData,
  output logic         full,
  output logic [W-1:0] rData,
  output logic         rValid,
  input  logic         rReady
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wBin, wGray, rBin, rGray;
  logic [AW:0]  wq1, wq2, rq1, rq2;
  logic [AW:0]  wBinNext, rBinNext;
  logic         rEn;

  assign wBinNext = wBin + 1'b1;
  assign rBinNext = rBin + 1'b1;
  assign full     = (wGray == {~wq2[AW:AW-1], wq2[AW-2:0]});
  assign rValid   = (rGray != rq2);
  assign rEn      = rValid && rReady;
  assign rData    = mem[rBin[AW-1:0]];

  always_ff @(posedge wClk) begin
    if (wEn && !full) mem[wBin[AW-1:0]] <= wData;
  end

  always_ff @(posedge wClk or negedge rstN) begin
    if (!rstN) begin
      wBin <= '0; wGray <= '0; wq1 <= '0; wq2 <= '0;
    end else begin
      wq1 <= rGray;
      wq2 <= wq1;
      if (wEn && !full) begin
        wBin  <= wBinNext;
        wGray <= wBinNext ^ (wBinNext >> 1);
      end
    end
  end

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN) begin
      rBin <= '0; rGray <= '0; rq1 <= '0; rq2 <= '0;
    end else begin
      rq1 <= wGray;
      rq2 <= rq1;
      if (rEn) begin
        rBin  <= rBinNext;
        rGray <= rBinNext ^ (rBinNext >> 1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wClk) disable iff (!rstN)
    wEn |-> !full); // R10
  AST_OUT_HOLD: assert property (@(posedge rClk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData))); // R10
endmodule

// File: rtl/hitcore_top.sv
module hitcore_top
  import hitcore_pkg::*;
#(
  parameter int FIFO_AW = 3,
  parameter int LOSTW   = 16
) (
  input  logic                bcoClk,
  input  logic                roClk,
  input  logic                rstN,
  input  logic [CHANNELS-1:0] discIn,
  input  logic [CHANNELS-1:0] killMask,
  input  logic                rejectHits,
  input  logic                sendData,
  input  logic                acqCrossing,
  output logic [STAMPW-1:0]   crossingNow,
  output logic [STAMPW-1:0]   crossingHeld,
  output logic [LOSTW-1:0]    lostCount,
  output logic                outValid,
  input  logic                outReady,
  output logic [GROUPW-1:0]   outGroup,
  output logic [STRIPW-1:0]   outStrip,
  output logic [STAMPW-1:0]   outStamp
);
  localparam int RECW = $bits(hitRec_t);

  ctrlStb_t           stb;
  logic [NGROUPS-1:0] req;
  hitRec_t            wrRec;
  hitRec_t            rdRec;
  logic [RECW-1:0]    rdBits;
  logic               fifoFull;

  hitcore_ctrl u_ctrl (
    .clk         (bcoClk),
    .rstN        (rstN),
    .sendData    (sendData),
    .acqCrossing (acqCrossing),
    .req         (req),
    .fifoFull    (fifoFull),
    .stb         (stb),
    .crossNow    (crossingNow),
    .crossHeld   (crossingHeld)
  );

  hitcore_datapath #(.LOSTW(LOSTW)) u_path (
    .clk        (bcoClk),
    .rstN       (rstN),
    .discIn     (discIn),
    .killMask   (killMask),
    .rejectHits (rejectHits),
    .crossNow   (crossingNow),
    .stb        (stb),
    .req        (req),
    .wrRec      (wrRec),
    .lostCount  (lostCount)
  );

  hitcore_afifo #(.W(RECW), .AW(FIFO_AW)) u_fifo (
    .wClk   (bcoClk),
    .rClk   (roClk),
    .rstN   (rstN),
    .wEn    (stb.push),
    .wData  (wrRec),
    .full   (fifoFull),
    .rData  (rdBits),
    .rValid (outValid),
    .rReady (outReady)
  );

  assign rdRec    = hitRec_t'(rdBits);
  assign outGroup = rdRec.grp;
  assign outStrip = rdRec.strip;
  assign outStamp = rdRec.stamp;
endmodule

// File: tb/sim_hitcore_top.sv
module sim_hitcore_top;
  logic         bcoClk = 0;
  logic         roClk = 0;
  logic         rstN = 0;
  logic [127:0] discIn = '0;
  logic [127:0] killMask = '0;
  logic         rejectHits = 0;
  logic         sendData = 0;
  logic         acqCrossing = 0;
  logic         outReady = 0;
  logic [7:0]   crossingNow, crossingHeld, outStamp;
  logic [15:0]  lostCount;
  logic         outValid;
  logic [4:0]   outGroup;
  logic [3:0]   outStrip;

  always #4 bcoClk = ~bcoClk;
  always #5.5 roClk = ~roClk;

  hitcore_top u0 (
    .bcoClk(bcoClk), .roClk(roClk), .rstN(rstN), .discIn(discIn),
    .killMask(killMask), .rejectHits(rejectHits), .sendData(sendData),
    .acqCrossing(acqCrossing), .crossingNow(crossingNow),
    .crossingHeld(crossingHeld), .lostCount(lostCount), .outValid(outValid),
    .outReady(outReady), .outGroup(outGroup), .outStrip(outStrip),
    .outStamp(outStamp)
  );

  int nChecks = 0;
  int nFail = 0;
  string curReq = "R2";

  int eGrp [4096];
  int eStrip [4096];
  int eStamp [4096];
  int eHead = 0;
  int eTail = 0;

  int mPend [16];
  int mStamp [16];
  int mLast = 15;
  int mLost = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model of one crossing with the current inputs, then advance one cycle.
  task automatic step();
    int st;
    st = int'(crossingNow);
    for (int g = 0; g < 16; g++) begin
      int live;
      int cnt;
      live = int'(discIn[g*8 +: 8] & ~killMask[g*8 +: 8]);
      cnt = 0;
      for (int b = 0; b < 8; b++) cnt += (live >> b) & 1;
      if (!rejectHits && live != 0) begin
        if (mPend[g] == 0) begin
          mPend[g] = live;
          mStamp[g] = st;
        end else begin
          mLost += cnt;
          if (mLost > 65535) mLost = 65535;
        end
      end
    end
    @(negedge bcoClk);
  endtask

  task automatic buildExpected();
    int found;
    forever begin
      found = -1;
      for (int i = 1; i <= 16; i++) begin
        int gi;
        gi = (mLast + i) % 16;
        if (found < 0 && mPend[gi] != 0) found = gi;
      end
      if (found < 0) break;
      for (int s = 0; s < 8; s++) begin
        if (((mPend[found] >> s) & 1) == 1) begin
          eGrp[eTail] = found;
          eStrip[eTail] = s;
          eStamp[eTail] = mStamp[found];
          eTail++;
          mPend[found] = mPend[found] & ~(1 << s);
          break;
        end
      end
      mLast = found;
    end
  endtask

  task automatic drain(input string req);
    buildExpected();
    for (int i = 0; i < 4000 && eHead != eTail; i++) @(negedge bcoClk);
    check(eHead == eTail, req, "all records delivered", eHead, eTail);
    repeat (20) @(negedge bcoClk);
    check(!outValid, req, "no extra record", int'(outValid), 0);
  endtask

  // Readout side with backpressure; R10 stall checks and record compares.
  initial begin
    bit prevStall;
    int pG, pS, pT, rc;
    prevStall = 0; pG = 0; pS = 0; pT = 0; rc = 0;
    forever begin
      @(negedge roClk);
      if (rstN) begin
        if (prevStall)
          check(outValid && int'(outGroup) == pG && int'(outStrip) == pS &&
                int'(outStamp) == pT, "R10", "stalled record held",
                int'({outValid, outGroup, outStrip, outStamp}),
                int'({1'b1, 5'(pG), 4'(pS), 8'(pT)}));
        rc++;
        outReady = ((rc % 5) != 2) && ((rc % 37) < 30);
        if (outValid && outReady) begin
          if (eHead == eTail)
            check(0, curReq, "unexpected record",
                  int'({outGroup, outStrip, outStamp}), -1);
          else begin
            check(int'(outGroup) == eGrp[eHead] && int'(outStrip) == eStrip[eHead] &&
                  int'(outStamp) == eStamp[eHead], curReq, "record {grp,strip,stamp}",
                  int'({outGroup, outStrip, outStamp}),
                  int'({5'(eGrp[eHead]), 4'(eStrip[eHead]), 8'(eStamp[eHead])}));
            eHead++;
          end
        end
        prevStall = outValid && !outReady;
        pG = int'(outGroup); pS = int'(outStrip); pT = int'(outStamp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge bcoClk);
    check(0, "R10", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int v;
    for (int g = 0; g < 16; g++) begin mPend[g] = 0; mStamp[g] = 0; end
    repeat (3) @(negedge bcoClk);
    check(crossingNow == 0, "R4", "count in reset", int'(crossingNow), 0);
    check(crossingHeld == 0, "R8", "held in reset", int'(crossingHeld), 0);
    check(lostCount == 0, "R9", "lost in reset", int'(lostCount), 0);
    check(!outValid, "R10", "valid in reset", int'(outValid), 0);
    rstN = 1;

    // R4: step and wrap
    for (int i = 0; i < 300; i++) begin
      v = int'(crossingNow);
      @(negedge bcoClk);
      check(int'(crossingNow) == ((v + 1) & 255), "R4", "count step",
            int'(crossingNow), (v + 1) & 255);
    end

    // R8: acquire and hold
    repeat (3) @(negedge bcoClk);
    acqCrossing = 1; v = int'(crossingNow);
    @(negedge bcoClk);
    acqCrossing = 0;
    check(int'(crossingHeld) == v, "R8", "acquired value", int'(crossingHeld), v);
    repeat (7) @(negedge bcoClk);
    check(int'(crossingHeld) == v, "R8", "held value kept", int'(crossingHeld), v);

    // R5: records wait for send enable
    curReq = "R5";
    sendData = 0;
    discIn[4*8 +: 8] = 8'h5A;
    step();
    discIn = '0;
    buildExpected();
    repeat (30) @(negedge bcoClk);
    check(!outValid, "R5", "no output while send low", int'(outValid), 0);
    check(eHead == 0, "R5", "nothing consumed", eHead, 0);
    sendData = 1;
    drain("R5");

    // R1 R2 R3: sweep groups, hit and kill patterns
    curReq = "R1 R2 R3";
    for (int p = 0; p < 256; p++) begin
      int g;
      g = p % 16;
      discIn[g*8 +: 8] = 8'(p);
      killMask[g*8 +: 8] = 8'((p * 29 + 7) & 8'h96);
      step();
      discIn = '0;
      killMask = '0;
      drain("R1 R2 R3");
    end
    check(lostCount == 0, "R3", "no loss in sweep", int'(lostCount), 0);

    // R7: rotation across groups; group 0 captured one crossing later
    curReq = "R7";
    sendData = 0;
    discIn[2*8 +: 8] = 8'h03;
    discIn[5*8 +: 8] = 8'h81;
    discIn[9*8 +: 8] = 8'h1C;
    discIn[15*8 +: 8] = 8'h40;
    step();
    discIn = '0;
    discIn[0*8 +: 8] = 8'hA0;
    step();
    discIn = '0;
    repeat (5) @(negedge bcoClk);
    sendData = 1;
    drain("R7");

    // R9 R6: loss at a busy group, reject ignored
    curReq = "R9";
    sendData = 0;
    discIn[3*8 +: 8] = 8'h0F;
    step();
    discIn = '0;
    discIn[3*8 +: 8] = 8'h30;
    killMask[3*8 +: 8] = 8'h20;
    step();
    discIn = '0; killMask = '0;
    rejectHits = 1;
    discIn[3*8 +: 8] = 8'hFF;
    discIn[7*8 +: 8] = 8'hFF;
    step();
    discIn = '0;
    rejectHits = 0;
    @(negedge bcoClk);
    check(int'(lostCount) == mLost, "R9", "lost count", int'(lostCount), mLost);
    check(mLost == 1, "R6", "model lost after reject", mLost, 1);
    discIn[3*8 +: 8] = 8'hC0;
    step();
    discIn = '0;
    @(negedge bcoClk);
    check(int'(lostCount) == mLost, "R9", "lost count second", int'(lostCount), mLost);
    curReq = "R6";
    sendData = 1;
    drain("R6");

    // R9: saturation with all channels flooding, then full drain
    curReq = "R9";
    sendData = 0;
    discIn = '1;
    for (int i = 0; i < 601; i++) step();
    discIn = '0;
    @(negedge bcoClk);
    check(lostCount == 16'hFFFF, "R9", "saturated", int'(lostCount), 65535);
    check(mLost == 65535, "R9", "model saturated", mLost, 65535);
    curReq = "R7";
    sendData = 1;
    drain("R7");
    check(lostCount == 16'hFFFF, "R9", "saturation held", int'(lostCount), 65535);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule